// File: doc/BRIEF.md
# IOTLB Invalidation Request Controller

This block holds the 64-bit control register of one IOTLB invalidation unit in a DMA-remapping engine and runs the sequence that follows a request. Software writes the register through a byte-enabled write port. Setting the request bit in the top byte starts a request, and the requested granularity is written in the same byte. The controller waits while a context-cache invalidation is pending. When the write-buffer flush capability is configured, it first completes a flush. It then asks the TLB to invalidate at the granularity it can actually support. When the TLB answers, the controller clears the request bit and records the granularity it used.

There are two handshakes toward the memory system, one for the flush and one for the invalidation. Each is a level request that the block holds high until the matching acknowledge is seen. The acknowledge is a one-cycle pulse that may arrive any number of cycles later, so the responder applies back-pressure simply by delaying the pulse. The two requests are never high at the same time. The read port is combinational and always shows the live register. Writes that arrive while a request is outstanding are refused and set a sticky error flag.

Top module: `tlb_inval_ctl`

Register fields (bit positions):

| Bits | Field | Access |
|------|-------|--------|
| 63 | request / busy | RW |
| 61:60 | requested granularity | RW |
| 58:57 | granularity actually used | RO |
| 56 | protocol error | sticky, write 1 to clear |
| 47:0 | target field | RW |
| 62, 59, 55:48 | reserved | read as 0 |

Granularity codes: 01 global, 10 domain, 11 page, 00 reserved.

## Requirements
- R1: After reset the register reads all zeros, and both `tlb_req` and `flush_req` are low.
- R2: A request starts only when a write hits the register quadword (`wr_addr[11:3]` equals `BASE_ADDR[11:3]`) with `wr_be[7]` set and `wr_data[63]` = 1. Writes that skip byte lane 7 do not start one, and writes to other addresses do not start one.
- R3: While `ctx_pend` is high, neither `flush_req` nor `tlb_req` is raised. A request written during that time keeps bit 63 set and starts after `ctx_pend` falls.
- R4: With `FLUSH_CAP`=1, exactly one flush handshake completes before `tlb_req` rises. With `FLUSH_CAP`=0, `flush_req` never rises.
- R5: `tlb_req` and `flush_req` each stay high until their acknowledge is sampled, and the two are never high together.
- R6: Bit 63 reads 0 from the clock edge at which `tlb_ack` is sampled with `tlb_req` high. Each request produces exactly one invalidation handshake.
- R7: Requested code 11 is kept as 11 when `PAGE_OK`=1 and becomes domain (10) otherwise. Code 10 stays 10, and codes 01 and 00 become global (01). The resolved code drives `tlb_gran` and is written to bits 58:57 on completion.
- R8: A write that hits the register while bit 63 is set leaves bit 63, bits 61:60 and bits 47:0 unchanged, and sets bit 56.
- R9: Writing 1 to bit 56 through byte lane 7 clears the error flag while the unit is idle. Writes never change bits 58:57, and reserved bits always read 0.
- R10: While the unit is idle, each set byte enable 0..5 writes its byte of bits 47:0, and the other bytes of that field keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_be | input | 8 | Byte enables of the write |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Live register contents |
| ctx_pend | input | 1 | A context-cache invalidation is pending |
| flush_req | output | 1 | Write-buffer flush request, held until acknowledged |
| flush_ack | input | 1 | One-cycle flush completion pulse |
| tlb_req | output | 1 | IOTLB invalidation request, held until acknowledged |
| tlb_gran | output | 2 | Granularity used for the invalidation |
| tlb_ack | input | 1 | One-cycle invalidation completion pulse |

## Verification
Two instances run side by side on the same write stream: one flushes and lacks page granularity, the other skips the flush and supports pages. Requests are swept over all four granularity codes, with and without a held context-pending input, and with immediate and delayed acknowledges. This separates the effect of the fallback mapping from the flush ordering and from the context gate. Separate write patterns cover the start rule: the missing top lane, a foreign address, partial byte lanes, writes to the read-only field, and a full write landing during a busy window. Together they distinguish a write that starts a request from one that only stores data or that must be refused.

// File: rtl/tlb_inval_pkg.sv
package tlb_inval_pkg;

  typedef enum logic [1:0] {
    GR_RSVD   = 2'b00,
    GR_GLOBAL = 2'b01,
    GR_DOMAIN = 2'b10,
    GR_PAGE   = 2'b11
  } gran_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_CTX,
    S_FLUSH,
    S_INVAL,
    S_DONE
  } seq_e;

  localparam int REG_W     = 64;
  localparam int REG_BYTES = REG_W / 8;
  localparam int GO_BIT    = 63;
  localparam int RQG_LO    = 60;
  localparam int ACG_LO    = 57;
  localparam int ERR_BIT   = 56;
  localparam int TGT_W     = 48;

endpackage

// File: rtl/tlb_inval_gran.sv
module tlb_inval_gran
  import tlb_inval_pkg::*;
#(
  parameter bit PAGE_OK = 1'b1
) (
  input  gran_e req_gran,
  output gran_e use_gran
);

  generate
    if (PAGE_OK) begin : g_page
      always_comb begin
        unique case (req_gran)
          GR_PAGE:   use_gran = GR_PAGE;
          GR_DOMAIN: use_gran = GR_DOMAIN;
          default:   use_gran = GR_GLOBAL;
        endcase
      end
    end else begin : g_nopage
      always_comb begin
        unique case (req_gran)
          GR_PAGE,
          GR_DOMAIN: use_gran = GR_DOMAIN;
          default:   use_gran = GR_GLOBAL;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/tlb_inval_regs.sv
module tlb_inval_regs
  import tlb_inval_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h108
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_BYTES-1:0] wr_be,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              done,
  input  gran_e             done_gran,
  output logic              go,
  output gran_e             req_gran,
  output logic [REG_W-1:0]  rd_data
);

  localparam int LANE_BITS = $clog2(REG_BYTES);
  localparam int TGT_BYTES = TGT_W / 8;
  localparam int TOP_LANE  = REG_BYTES - 1;

  logic             go_q;
  gran_e            rqg_q;
  gran_e            acg_q;
  logic             err_q;
  logic [TGT_W-1:0] tgt_q;

  logic hit, idle_wr, busy_wr, top_wr;

  assign hit     = wr_en && (wr_addr[ADDR_W-1:LANE_BITS] == BASE_ADDR[ADDR_W-1:LANE_BITS]);
  assign idle_wr = hit && !go_q;
  assign busy_wr = hit && go_q;
  assign top_wr  = idle_wr && wr_be[TOP_LANE];

  // target field, one register per byte lane
  genvar b;
  generate
    for (b = 0; b < TGT_BYTES; b++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n)
          tgt_q[b*8 +: 8] <= '0;
        else if (idle_wr && wr_be[b])
          tgt_q[b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  endgenerate

  // request bit and requested granularity
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q  <= 1'b0;
      rqg_q <= GR_RSVD;
    end else if (done) begin
      go_q  <= 1'b0;
    end else if (top_wr) begin
      go_q  <= wr_data[GO_BIT];
      rqg_q <= gran_e'(wr_data[RQG_LO +: 2]);
    end
  end

  // granularity used, written by hardware only
  always_ff @(posedge clk) begin
    if (!rst_n)
      acg_q <= GR_RSVD;
    else if (done)
      acg_q <= done_gran;
  end

  // sticky protocol error
  always_ff @(posedge clk) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (busy_wr)
      err_q <= 1'b1;
    else if (top_wr && wr_data[ERR_BIT])
      err_q <= 1'b0;
  end

  assign go       = go_q;
  assign req_gran = rqg_q;
  assign rd_data  = {go_q, 1'b0, rqg_q, 1'b0, acg_q, err_q, 8'h00, tgt_q};

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_addr[LANE_BITS-1:0], wr_data[62], wr_data[59:57],
                            wr_data[55:48], wr_be[TOP_LANE-1:TGT_BYTES]};

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_wr |=> ($stable(tgt_q) && $stable(rqg_q) && err_q));

  // R2
  go_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> $past(top_wr && wr_data[GO_BIT]));

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !go_q);

  // R9
  err_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_wr && wr_data[ERR_BIT]) |=> !err_q);

  // R9
  acg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(acg_q));

endmodule

// File: rtl/tlb_inval_seq.sv
module tlb_inval_seq
  import tlb_inval_pkg::*;
#(
  parameter bit FLUSH_CAP = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  input  gran_e use_gran,
  input  logic  ctx_pend,
  input  logic  flush_ack,
  input  logic  tlb_ack,
  output logic  flush_req,
  output logic  tlb_req,
  output gran_e tlb_gran,
  output logic  done,
  output gran_e done_gran
);

  seq_e  state_q, state_d;
  gran_e gran_q;
  logic  flushed_q;
  logic  need_flush;

  assign need_flush = FLUSH_CAP && !flushed_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (go) begin
          if (ctx_pend)       state_d = S_WAIT_CTX;
          else if (FLUSH_CAP) state_d = S_FLUSH;
          else                state_d = S_INVAL;
        end
      end
      S_WAIT_CTX: begin
        if (!ctx_pend) state_d = need_flush ? S_FLUSH : S_INVAL;
      end
      S_FLUSH: begin
        if (flush_ack) state_d = ctx_pend ? S_WAIT_CTX : S_INVAL;
      end
      S_INVAL: begin
        if (tlb_ack) state_d = S_DONE;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      gran_q    <= GR_GLOBAL;
      flushed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && go) begin
        gran_q    <= use_gran;
        flushed_q <= 1'b0;
      end else if (state_q == S_FLUSH && flush_ack) begin
        flushed_q <= 1'b1;
      end
    end
  end

  generate
    if (FLUSH_CAP) begin : g_flush
      assign flush_req = (state_q == S_FLUSH);
    end else begin : g_noflush
      assign flush_req = 1'b0;
      logic unused_flush_ack;
      assign unused_flush_ack = flush_ack;
    end
  endgenerate

  assign tlb_req   = (state_q == S_INVAL);
  assign tlb_gran  = gran_q;
  assign done      = tlb_req && tlb_ack;
  assign done_gran = gran_q;

  // R5
  req_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tlb_req && flush_req));

  // R5
  tlb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req && !tlb_ack) |=> tlb_req);

  // R5
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack) |=> flush_req);

  // R3
  ctx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tlb_req) || $rose(flush_req)) |-> !$past(ctx_pend));

  // R4
  flush_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tlb_req) |-> (flushed_q == FLUSH_CAP));

endmodule

// File: rtl/tlb_inval_ctl.sv
module tlb_inval_ctl
  import tlb_inval_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h108,
  parameter bit              FLUSH_CAP = 1'b1,
  parameter bit              PAGE_OK   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_be,
  input  logic [63:0]       wr_data,
  output logic [63:0]       rd_data,
  input  logic              ctx_pend,
  output logic              flush_req,
  input  logic              flush_ack,
  output logic              tlb_req,
  output logic [1:0]        tlb_gran,
  input  logic              tlb_ack
);

  logic  go, done;
  gran_e req_gran, use_gran, done_gran, seq_gran;

  tlb_inval_regs #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .done     (done),
    .done_gran(done_gran),
    .go       (go),
    .req_gran (req_gran),
    .rd_data  (rd_data)
  );

  tlb_inval_gran #(.PAGE_OK(PAGE_OK)) u_gran (
    .req_gran(req_gran),
    .use_gran(use_gran)
  );

  tlb_inval_seq #(.FLUSH_CAP(FLUSH_CAP)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .use_gran (use_gran),
    .ctx_pend (ctx_pend),
    .flush_ack(flush_ack),
    .tlb_ack  (tlb_ack),
    .flush_req(flush_req),
    .tlb_req  (tlb_req),
    .tlb_gran (seq_gran),
    .done     (done),
    .done_gran(done_gran)
  );

  assign tlb_gran = seq_gran;

  // R6
  ack_clears_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req && tlb_ack) |=> !rd_data[GO_BIT]);

  // R7
  gran_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req |-> (tlb_gran != 2'b00) && (PAGE_OK || tlb_gran != 2'b11));

endmodule

// File: tb/tb_tlb_inval_ctl.sv
`timescale 1ns/1ps

module tb_ack_model (
  input  logic clk,
  input  logic req,
  input  int   dly,
  output logic ack
);
  int cnt;
  initial begin
    ack = 1'b0;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 1'b0;
        cnt = 0;
      end else if (req) begin
        if (cnt >= dly) ack = 1'b1;
        else cnt++;
      end else begin
        cnt = 0;
      end
    end
  end
endmodule

module tb_port_watch (
  input  logic       clk,
  input  logic       clr,
  input  logic       tlb_req,
  input  logic       tlb_ack,
  input  logic [1:0] tlb_gran,
  input  logic       flush_req,
  input  logic       flush_ack,
  input  logic       ctx_pend,
  input  logic       go,
  output int         flush_n,
  output int         tlb_n,
  output int         flush_at_tlb,
  output logic [1:0] gran_at,
  output int         bad_ctx,
  output int         bad_go,
  output int         bad_mutex
);
  logic prev_t, prev_f;
  initial begin
    prev_t = 0; prev_f = 0;
    flush_n = 0; tlb_n = 0; flush_at_tlb = -1; gran_at = 2'b00;
    bad_ctx = 0; bad_go = 0; bad_mutex = 0;
    forever begin
      @(posedge clk);
      #2;
      if (clr) begin
        flush_n = 0; tlb_n = 0; flush_at_tlb = -1; gran_at = 2'b00;
        bad_ctx = 0; bad_go = 0; bad_mutex = 0;
      end else begin
        if (flush_ack) flush_n++;
        if (tlb_ack) begin
          tlb_n++;
          if (go || tlb_req) bad_go++;
        end
        if (tlb_req && !prev_t) begin
          flush_at_tlb = flush_n;
          gran_at = tlb_gran;
          if (ctx_pend) bad_ctx++;
        end
        if (flush_req && !prev_f && ctx_pend) bad_ctx++;
        if (tlb_req && flush_req) bad_mutex++;
      end
      prev_t = tlb_req;
      prev_f = flush_req;
    end
  end
endmodule

module tb_tlb_inval_ctl;

  localparam logic [11:0] BASE = 12'h108;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [7:0]  wr_be;
  logic [63:0] wr_data;
  logic        ctx_pend;
  logic        wclr;
  int          dly;

  logic [63:0] rd_a, rd_b;
  logic        freq_a, fack_a, treq_a, tack_a;
  logic        freq_b, fack_b, treq_b, tack_b;
  logic [1:0]  tgr_a, tgr_b;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tlb_inval_ctl #(.BASE_ADDR(BASE), .FLUSH_CAP(1'b1), .PAGE_OK(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_a), .ctx_pend(ctx_pend),
    .flush_req(freq_a), .flush_ack(fack_a), .tlb_req(treq_a),
    .tlb_gran(tgr_a), .tlb_ack(tack_a)
  );

  tlb_inval_ctl #(.BASE_ADDR(BASE), .FLUSH_CAP(1'b0), .PAGE_OK(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_data(rd_b), .ctx_pend(ctx_pend),
    .flush_req(freq_b), .flush_ack(fack_b), .tlb_req(treq_b),
    .tlb_gran(tgr_b), .tlb_ack(tack_b)
  );

  tb_ack_model u_fa (.clk(clk), .req(freq_a), .dly(dly), .ack(fack_a));
  tb_ack_model u_ta (.clk(clk), .req(treq_a), .dly(dly), .ack(tack_a));
  tb_ack_model u_fb (.clk(clk), .req(freq_b), .dly(dly), .ack(fack_b));
  tb_ack_model u_tb (.clk(clk), .req(treq_b), .dly(dly), .ack(tack_b));

  int fn_a, tn_a, fat_a, bc_a, bg_a, bm_a;
  int fn_b, tn_b, fat_b, bc_b, bg_b, bm_b;
  logic [1:0] ga_a, ga_b;

  tb_port_watch u_wa (.clk(clk), .clr(wclr), .tlb_req(treq_a), .tlb_ack(tack_a),
    .tlb_gran(tgr_a), .flush_req(freq_a), .flush_ack(fack_a), .ctx_pend(ctx_pend),
    .go(rd_a[63]), .flush_n(fn_a), .tlb_n(tn_a), .flush_at_tlb(fat_a),
    .gran_at(ga_a), .bad_ctx(bc_a), .bad_go(bg_a), .bad_mutex(bm_a));
  tb_port_watch u_wb (.clk(clk), .clr(wclr), .tlb_req(treq_b), .tlb_ack(tack_b),
    .tlb_gran(tgr_b), .flush_req(freq_b), .flush_ack(fack_b), .ctx_pend(ctx_pend),
    .go(rd_b[63]), .flush_n(fn_b), .tlb_n(tn_b), .flush_at_tlb(fat_b),
    .gran_at(ga_b), .bad_ctx(bc_b), .bad_go(bg_b), .bad_mutex(bm_b));

  // bench-side register model
  logic [47:0] m_tgt;
  logic [1:0]  m_rqg, m_acg_a, m_acg_b;
  logic        m_err;

  function automatic logic [63:0] mk(logic g, logic [1:0] rq, logic [1:0] ac,
                                     logic e, logic [47:0] t);
    return {g, 1'b0, rq, 1'b0, ac, e, 8'h00, t};
  endfunction

  function automatic logic [1:0] exp_gran(logic [1:0] code, logic page_ok);
    if (code == 2'b11) return page_ok ? 2'b11 : 2'b10;
    if (code == 2'b10) return 2'b10;
    return 2'b01;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] be, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic model_lanes(logic [7:0] be, logic [63:0] d);
    for (int b = 0; b < 6; b++)
      if (be[b]) m_tgt[b*8 +: 8] = d[b*8 +: 8];
  endtask

  task automatic clear_watch();
    @(negedge clk); wclr = 1'b1;
    @(negedge clk); wclr = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((rd_a[63] || rd_b[63]) && t < 500) begin
      @(negedge clk);
      t++;
    end
    chk("R6 request completes before timeout", 64'(t < 500), 64'd1);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_req(logic [1:0] code, logic hold, int d);
    dly = d;
    clear_watch();
    if (hold) ctx_pend = 1'b1;
    wr(BASE, 8'h80, mk(1'b1, code, 2'b00, 1'b0, 48'h0));
    m_rqg = code;
    if (hold) begin
      repeat (6) @(negedge clk);
      chk("R3 held request stays set (dut)", 64'(rd_a[63]), 64'd1);
      chk("R3 held request stays set (alt)", 64'(rd_b[63]), 64'd1);
      chk("R3 no handshake while pending", 64'(fn_a + tn_a + fn_b + tn_b +
          freq_a + treq_a + treq_b), 64'd0);
      ctx_pend = 1'b0;
    end
    wait_idle();
    m_acg_a = exp_gran(code, 1'b0);
    m_acg_b = exp_gran(code, 1'b1);
    chk("R7 register after completion (dut)", rd_a, mk(0, m_rqg, m_acg_a, m_err, m_tgt));
    chk("R7 register after completion (alt)", rd_b, mk(0, m_rqg, m_acg_b, m_err, m_tgt));
    chk("R7 tlb_gran (dut)", 64'(ga_a), 64'(m_acg_a));
    chk("R7 tlb_gran (alt)", 64'(ga_b), 64'(m_acg_b));
    chk("R4 one flush before invalidate (dut)", 64'(fat_a), 64'd1);
    chk("R4 no flush without capability (alt)", 64'(fn_b), 64'd0);
    chk("R6 single handshake each", 64'(tn_a * 16 + tn_b), 64'h11);
    chk("R6 request bit low after ack", 64'(bg_a + bg_b), 64'd0);
    chk("R3 no start while pending", 64'(bc_a + bc_b), 64'd0);
    chk("R5 requests exclusive", 64'(bm_a + bm_b), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_be = '0; wr_data = '0;
    ctx_pend = 1'b0; wclr = 1'b0; dly = 0;
    m_tgt = '0; m_rqg = 2'b00; m_acg_a = 2'b00; m_acg_b = 2'b00; m_err = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reset value (dut)", rd_a, 64'h0);
    chk("R1 reset value (alt)", rd_b, 64'h0);
    chk("R1 handshakes idle", 64'({freq_a, treq_a, freq_b, treq_b}), 64'h0);

    // R10 partial byte lanes
    wr(BASE, 8'h05, 64'h0000_1122_3344_5566);
    model_lanes(8'h05, 64'h0000_1122_3344_5566);
    chk("R10 lanes 0 and 2 only", rd_a, mk(0, 0, 0, 0, m_tgt));
    wr(BASE, 8'h3A, 64'h0000_A1B2_C3D4_E5F6);
    model_lanes(8'h3A, 64'h0000_A1B2_C3D4_E5F6);
    chk("R10 lanes 1,3,4,5 merged", rd_b, mk(0, 0, 0, 0, m_tgt));

    // R2 start rule
    clear_watch();
    wr(BASE, 8'h7F, 64'hFFFF_FFFF_FFFF_FFFF);
    model_lanes(8'h7F, 64'hFFFF_FFFF_FFFF_FFFF);
    repeat (5) @(negedge clk);
    chk("R2 no start without top lane", rd_a, mk(0, 0, 0, 0, m_tgt));
    chk("R2 no handshake without top lane", 64'(fn_a + tn_a + tn_b + freq_a + treq_b), 64'd0);
    wr(12'h110, 8'hFF, 64'h8000_0000_0000_1234);
    repeat (5) @(negedge clk);
    chk("R2 foreign address ignored", rd_b, mk(0, 0, 0, 0, m_tgt));
    chk("R2 no handshake on foreign address", 64'(tn_a + tn_b + treq_a + freq_a), 64'd0);

    // sweep granularity x context hold x acknowledge delay
    for (int c = 0; c < 4; c++)
      for (int h = 0; h < 2; h++)
        for (int d = 0; d < 2; d++)
          run_req(2'(c), h[0], d * 3);

    // R8 writes during a busy window
    dly = 12;
    clear_watch();
    wr(BASE, 8'h80, mk(1'b1, 2'b11, 2'b00, 1'b0, 48'h0));
    m_rqg = 2'b11;
    wr(BASE, 8'hFF, 64'h3FFF_FFFF_FFFF_FFFF);
    m_err = 1'b1;
    chk("R8 busy write refused (dut)", rd_a, mk(1, m_rqg, m_acg_a, 1, m_tgt));
    chk("R8 busy write refused (alt)", rd_b, mk(1, m_rqg, m_acg_b, 1, m_tgt));
    wr(BASE, 8'h80, mk(1'b1, 2'b01, 2'b00, 1'b0, 48'h0));
    wait_idle();
    m_acg_a = 2'b10;
    m_acg_b = 2'b11;
    chk("R8 error sticky after completion", rd_a, mk(0, 2'b11, m_acg_a, 1, m_tgt));
    chk("R8 one handshake despite busy writes", 64'(tn_a * 16 + tn_b), 64'h11);
    chk("R7 fallback of page code", 64'(ga_a * 4 + ga_b), 64'(4'b1011));

    // R9 error clear and read-only fields
    dly = 0;
    clear_watch();
    wr(BASE, 8'h80, mk(1'b0, 2'b01, 2'b00, 1'b1, 48'h0));
    m_rqg = 2'b01; m_err = 1'b0;
    chk("R9 error cleared by write one", rd_a, mk(0, m_rqg, m_acg_a, 0, m_tgt));
    wr(BASE, 8'hC0, 64'h7EFF_0000_0000_0000);
    m_rqg = 2'b11;
    repeat (4) @(negedge clk);
    chk("R9 read-only and reserved bits (dut)", rd_a, mk(0, m_rqg, m_acg_a, 0, m_tgt));
    chk("R9 read-only and reserved bits (alt)", rd_b, mk(0, m_rqg, m_acg_b, 0, m_tgt));
    chk("R2 writes with request bit clear start nothing", 64'(tn_a + tn_b + fn_a), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule